// File: doc/BRIEF.md
# Power-Managed Clock Mode Controller

This block decides which oscillator drives the system and whether the CPU and the peripherals receive clock edges. It runs on a fast reference clock and sees each oscillator as a tick input: one pulse per cycle of that oscillator. From those ticks it produces a CPU clock enable and a peripheral clock enable. A four-phase counter (phases 0 to 3) advances on every CPU clock enable. A sleep command is taken only on the CPU edge that ends phase 3. At that point the idle bit and the 2-bit source field select one of seven operating modes.

A change of source is glitch-safe. Both clock enables are held low while a fixed number of ticks of the new oscillator go by, and only then does the new source take over. The old oscillator is then released. Three status flags report which source is live. The block also turns interrupt and watchdog events into wake-ups, watchdog reset requests and a request to branch to the interrupt handler.

Top module: `clk_mode_ctrl`

## Requirements
- R1: With the idle bit low, an accepted sleep command selects a mode from the source field: 00 gives sleep (mode code 6), 01 gives secondary run (code 1), and 10 or 11 give internal run (code 2). In both run modes the CPU and the peripherals are clocked. Mode codes: 0 primary run, 1 secondary run, 2 internal run, 3 primary idle, 4 secondary idle, 5 internal idle, 6 sleep.
- R2: With the idle bit high, an accepted sleep command selects primary idle (field 00, code 3), secondary idle (01, code 4) or internal idle (1x, code 5). In an idle mode the CPU clock enable stays low and the peripheral clock enable keeps pulsing from the selected source.
- R3: In sleep, both clock enables and all three oscillator enables are low.
- R4: The primary oscillator enable is high only in primary run and primary idle.
- R5: The phase output resets to 0 and advances by one, wrapping at 3, on each CPU clock enable. A sleep command changes the mode only when it is present on a CPU clock enable that occurs in phase 3.
- R6: When the mode calls for a different source, both clock enables stay low for 8 ticks of the new source. The first enable after that pause falls on a tick of the new source.
- R7: The status flags (primary, secondary, internal) are never set together. Primary is set while the primary clock drives the system and reports ready. Secondary is set while the secondary clock drives the system. Internal is set while the internal block drives the system, but only if its fast path reports stable and the slow tap is not selected. None is set during a pause or in sleep.
- R8: An interrupt or a watchdog time-out in an idle mode or in sleep returns the block to primary run (code 0). The CPU keeps running on the source in use until primary ready is high. After that an automatic switch to primary follows.
- R9: On a wake from sleep with two-speed start disabled, the CPU clock stays off until primary ready. With it enabled, the CPU runs at once on the internal source.
- R10: A watchdog time-out in a run mode gives a one-cycle reset request and leaves the mode unchanged. In an idle mode or in sleep it gives a wake and no reset request. In every case a one-cycle time-out clear pulse follows.
- R11: An interrupt wake gives a one-cycle handler request when global interrupt enable is high, and none when it is low. An interrupt in a run mode has no effect on the mode or on the handler request.
- R12: After reset the mode is primary run, the phase is 0, the primary oscillator enable is high and, with primary ready, only the primary status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_tick | input | 1 | One pulse per primary oscillator cycle |
| sec_tick | input | 1 | One pulse per secondary oscillator cycle |
| int_tick | input | 1 | One pulse per internal block cycle |
| pri_ready | input | 1 | Primary oscillator has started and is stable |
| int_stable | input | 1 | Fast internal path is stable |
| tap_slow | input | 1 | Internal block set to its slow tap |
| src_sel | input | 2 | Source field: 00 primary, 01 secondary, 1x internal |
| idle_en | input | 1 | Idle bit applied by a sleep command |
| sleep_cmd | input | 1 | Sleep command from the CPU |
| irq | input | 1 | Interrupt wake event |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out |
| twospeed_en | input | 1 | Two-speed start or fail-safe monitor enabled |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| sec_osc_en | output | 1 | Secondary oscillator enable |
| int_osc_en | output | 1 | Internal oscillator block enable |
| stat_pri | output | 1 | Primary drives the system |
| stat_sec | output | 1 | Secondary drives the system |
| stat_int | output | 1 | Internal fast path drives the system |
| mode_o | output | 3 | Current mode code |
| phase_o | output | 2 | Current CPU phase |
| irq_vec_req | output | 1 | Request to branch to the interrupt handler |
| wdt_reset_req | output | 1 | Watchdog reset request |
| wdt_flag_clr | output | 1 | Watchdog time-out flag clear |

## Verification
The hardest situation to reach is the wait after a wake in which primary ready is still low. Both the CPU-held case and the case where the CPU runs on another source depend on ready falling after the block has settled in a low-power mode. The bench therefore enters idle or sleep while ready is high, then drops ready, then fires the wake event, and only raises ready after it has counted CPU pulses over a window. The pause length is measured by counting ticks of the new source that pass with the enables held low, starting from the first sample after the mode change.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_SEC = 2'd1,
        SRC_INT = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        M_PRI_RUN  = 3'd0,
        M_SEC_RUN  = 3'd1,
        M_INT_RUN  = 3'd2,
        M_PRI_IDLE = 3'd3,
        M_SEC_IDLE = 3'd4,
        M_INT_IDLE = 3'd5,
        M_SLEEP    = 3'd6
    } mode_e;

    function automatic src_e mode_src(input mode_e m);
        case (m)
            M_SEC_RUN, M_SEC_IDLE: mode_src = SRC_SEC;
            M_INT_RUN, M_INT_IDLE: mode_src = SRC_INT;
            default:               mode_src = SRC_PRI;
        endcase
    endfunction

    function automatic logic is_run(input mode_e m);
        is_run = (m == M_PRI_RUN) || (m == M_SEC_RUN) || (m == M_INT_RUN);
    endfunction

endpackage

// File: rtl/cmc_mode_decode.sv
module cmc_mode_decode
    import cmc_pkg::*;
(
    input  logic       idle_en,
    input  logic [1:0] src_sel,
    output mode_e      mode_sel
);
    always_comb begin
        if (!idle_en) begin
            case (src_sel)
                2'b00:   mode_sel = M_SLEEP;
                2'b01:   mode_sel = M_SEC_RUN;
                default: mode_sel = M_INT_RUN;
            endcase
        end else begin
            case (src_sel)
                2'b00:   mode_sel = M_PRI_IDLE;
                2'b01:   mode_sel = M_SEC_IDLE;
                default: mode_sel = M_INT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmc_tick_mux.sv
module cmc_tick_mux
    import cmc_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0] ticks,
    input  src_e            sel,
    output logic            tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (int'(sel) == i) tick = ticks[i];
        end
    end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import cmc_pkg::*;
#(
    parameter int SWITCH_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_tick,
    input  logic       sec_tick,
    input  logic       int_tick,
    input  logic       pri_ready,
    input  logic       int_stable,
    input  logic       tap_slow,
    input  logic [1:0] src_sel,
    input  logic       idle_en,
    input  logic       sleep_cmd,
    input  logic       irq,
    input  logic       gie,
    input  logic       wdt_timeout,
    input  logic       twospeed_en,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       pri_osc_en,
    output logic       sec_osc_en,
    output logic       int_osc_en,
    output logic       stat_pri,
    output logic       stat_sec,
    output logic       stat_int,
    output logic [2:0] mode_o,
    output logic [1:0] phase_o,
    output logic       irq_vec_req,
    output logic       wdt_reset_req,
    output logic       wdt_flag_clr
);
    localparam int NSRC  = 3;
    localparam int CNT_W = $clog2(SWITCH_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SWITCH_TICKS - 1);

    typedef struct packed {
        mode_e            mode;
        src_e             cur;
        logic             sw;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       phase;
        logic             vec;
        logic             wrst;
        logic             wclr;
    } state_t;

    state_t st_d, st_q;

    logic [NSRC-1:0] ticks;
    logic            cur_tick, tgt_tick;
    mode_e           cmd_mode;
    src_e            tgt_src;
    logic            src_ok, live, accept, wake;

    assign ticks   = {int_tick, sec_tick, pri_tick};
    assign tgt_src = mode_src(st_q.mode);

    cmc_tick_mux #(.NSRC(NSRC)) u_cur_mux (.ticks(ticks), .sel(st_q.cur), .tick(cur_tick));
    cmc_tick_mux #(.NSRC(NSRC)) u_tgt_mux (.ticks(ticks), .sel(tgt_src),  .tick(tgt_tick));
    cmc_mode_decode u_dec (.idle_en(idle_en), .src_sel(src_sel), .mode_sel(cmd_mode));

    // Clock gating and status, all from registered state
    always_comb begin
        src_ok     = (st_q.cur != SRC_PRI) || pri_ready;
        live       = !st_q.sw && src_ok && (st_q.mode != M_SLEEP) && cur_tick;
        per_clk_en = live;
        cpu_clk_en = live && is_run(st_q.mode);

        pri_osc_en = (st_q.mode == M_PRI_RUN) || (st_q.mode == M_PRI_IDLE);
        sec_osc_en = (st_q.mode != M_SLEEP) && ((tgt_src == SRC_SEC) || (st_q.cur == SRC_SEC));
        int_osc_en = (st_q.mode != M_SLEEP) && ((tgt_src == SRC_INT) || (st_q.cur == SRC_INT));

        stat_pri = !st_q.sw && (st_q.mode != M_SLEEP) && (st_q.cur == SRC_PRI) && pri_ready;
        stat_sec = !st_q.sw && (st_q.mode != M_SLEEP) && (st_q.cur == SRC_SEC);
        stat_int = !st_q.sw && (st_q.mode != M_SLEEP) && (st_q.cur == SRC_INT)
                   && int_stable && !tap_slow;
    end

    // Next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.vec  = 1'b0;
        st_d.wrst = 1'b0;
        st_d.wclr = 1'b0;

        accept = cpu_clk_en && (st_q.phase == 2'd3) && sleep_cmd;
        wake   = !is_run(st_q.mode) && (irq || wdt_timeout);

        if (cpu_clk_en) st_d.phase = st_q.phase + 2'd1;

        if (wdt_timeout) begin
            st_d.wclr = 1'b1;
            if (is_run(st_q.mode)) st_d.wrst = 1'b1;
        end

        if (wake) begin
            st_d.mode  = M_PRI_RUN;
            st_d.sw    = 1'b0;
            st_d.cnt   = '0;
            st_d.phase = 2'd0;
            st_d.vec   = irq && gie;
            if (st_q.mode == M_SLEEP) st_d.cur = twospeed_en ? SRC_INT : SRC_PRI;
        end else begin
            if (accept) st_d.mode = cmd_mode;
            if (st_q.sw) begin
                if (tgt_tick) begin
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.sw  = 1'b0;
                        st_d.cnt = '0;
                        st_d.cur = tgt_src;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end else if ((st_d.mode != M_SLEEP) && (mode_src(st_d.mode) != st_q.cur)
                         && ((mode_src(st_d.mode) != SRC_PRI) || pri_ready)) begin
                st_d.sw  = 1'b1;
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_PRI_RUN, cur: SRC_PRI, sw: 1'b0, cnt: '0,
                      phase: 2'd0, vec: 1'b0, wrst: 1'b0, wclr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o        = st_q.mode;
    assign phase_o       = st_q.phase;
    assign irq_vec_req   = st_q.vec;
    assign wdt_reset_req = st_q.wrst;
    assign wdt_flag_clr  = st_q.wclr;

endmodule

// File: rtl/cmc_checker.sv
module cmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_cmd,
    input logic       wdt_timeout,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       pri_osc_en,
    input logic       sec_osc_en,
    input logic       int_osc_en,
    input logic       stat_pri,
    input logic       stat_sec,
    input logic       stat_int,
    input logic [2:0] mode_o,
    input logic [1:0] phase_o,
    input logic       wdt_reset_req,
    input logic       wdt_flag_clr
);
    // R5: a run mode is left without a wake only on a phase-3 CPU edge carrying a sleep command
    p_q4_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode_o) <= 3'd2) && (mode_o != $past(mode_o)))
        |-> $past(cpu_clk_en && (phase_o == 2'd3) && sleep_cmd));

    // R4: primary oscillator only in primary run and primary idle
    p_pri_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o != 3'd0) && (mode_o != 3'd3)) |-> !pri_osc_en);

    // R3: sleep leaves nothing clocked and no oscillator enabled
    p_sleep_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd6) |-> !(cpu_clk_en || per_clk_en || pri_osc_en || sec_osc_en || int_osc_en));

    // R2: no CPU edge in an idle mode
    p_idle_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o >= 3'd3) && (mode_o <= 3'd5)) |-> !cpu_clk_en);

    // R7: status flags never overlap
    p_stat_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_pri, stat_sec, stat_int}));

    // R10: a time-out in a run mode yields a reset request and a clear pulse
    p_wdt_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout && (mode_o <= 3'd2)) |=> (wdt_reset_req && wdt_flag_clr));
endmodule

bind clk_mode_ctrl cmc_checker u_cmc_checker (
    .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .wdt_timeout(wdt_timeout),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .pri_osc_en(pri_osc_en),
    .sec_osc_en(sec_osc_en), .int_osc_en(int_osc_en), .stat_pri(stat_pri),
    .stat_sec(stat_sec), .stat_int(stat_int), .mode_o(mode_o), .phase_o(phase_o),
    .wdt_reset_req(wdt_reset_req), .wdt_flag_clr(wdt_flag_clr)
);

// File: tb/clk_mode_ctrl_bench.sv
module clk_mode_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pri_tick = 0, sec_tick = 0, int_tick = 0;
    logic pri_ready = 1, int_stable = 1, tap_slow = 0;
    logic [1:0] src_sel = 0;
    logic idle_en = 0, sleep_cmd = 0, irq = 0, gie = 0, wdt_timeout = 0, twospeed_en = 0;
    logic cpu_clk_en, per_clk_en, pri_osc_en, sec_osc_en, int_osc_en;
    logic stat_pri, stat_sec, stat_int;
    logic [2:0] mode_o;
    logic [1:0] phase_o;
    logic irq_vec_req, wdt_reset_req, wdt_flag_clr;

    int errors = 0;
    int checks = 0;
    int n_cpu, n_per;
    int tcnt = 0;
    bit q4_ok;

    always #5 clk = ~clk;

    clk_mode_ctrl u_clk_mode_ctrl (.*);

    // oscillator ticks: primary every 2, secondary every 5, internal every 3 cycles
    always @(negedge clk) begin
        tcnt     <= tcnt + 1;
        pri_tick <= (tcnt % 2) == 0;
        sec_tick <= (tcnt % 5) == 0;
        int_tick <= (tcnt % 3) == 0;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; pri_ready = 1; int_stable = 1; tap_slow = 0; src_sel = 0;
        idle_en = 0; sleep_cmd = 0; irq = 0; gie = 0; wdt_timeout = 0; twospeed_en = 0;
        repeat (3) step();
        rst_n = 1;
        step();
    endtask

    // hold a sleep command until the mode changes; note whether the change followed a phase-3 CPU edge
    task automatic enter(input logic idl, input logic [1:0] src);
        logic [2:0] start;
        bit pa;
        start = mode_o;
        idle_en = idl; src_sel = src; sleep_cmd = 1;
        q4_ok = 0;
        for (int i = 0; i < 200; i++) begin
            pa = cpu_clk_en && (phase_o == 2'd3);
            step();
            if (mode_o != start) begin
                q4_ok = pa;
                break;
            end
        end
        sleep_cmd = 0;
    endtask

    task automatic observe(input int n);
        n_cpu = 0; n_per = 0;
        for (int i = 0; i < n; i++) begin
            if (cpu_clk_en) n_cpu++;
            if (per_clk_en) n_per++;
            step();
        end
    endtask

    // idle, src, mode, cpu active, per active, pri osc, status {pri,sec,int}
    typedef struct packed {
        logic       idl;
        logic [1:0] src;
        logic [2:0] mode;
        logic       cpu;
        logic       per;
        logic       pri;
        logic [2:0] stat;
    } vec_t;

    localparam vec_t TABLE [8] = '{
        '{1'b0, 2'b00, 3'd6, 1'b0, 1'b0, 1'b0, 3'b000},
        '{1'b0, 2'b01, 3'd1, 1'b1, 1'b1, 1'b0, 3'b010},
        '{1'b0, 2'b10, 3'd2, 1'b1, 1'b1, 1'b0, 3'b001},
        '{1'b0, 2'b11, 3'd2, 1'b1, 1'b1, 1'b0, 3'b001},
        '{1'b1, 2'b00, 3'd3, 1'b0, 1'b1, 1'b1, 3'b100},
        '{1'b1, 2'b01, 3'd4, 1'b0, 1'b1, 1'b0, 3'b010},
        '{1'b1, 2'b10, 3'd5, 1'b0, 1'b1, 1'b0, 3'b001},
        '{1'b1, 2'b11, 3'd5, 1'b0, 1'b1, 1'b0, 3'b001}
    };

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int gated;
        bit seen;
        do_reset();

        // R12: reset state
        chk(mode_o == 3'd0, "R12 mode after reset", mode_o, 0);
        chk(pri_osc_en == 1'b1, "R12 primary osc enable after reset", pri_osc_en, 1);
        chk({stat_pri, stat_sec, stat_int} == 3'b100, "R12 status after reset",
            {stat_pri, stat_sec, stat_int}, 3'b100);
        rst_n = 0; step();
        chk(phase_o == 2'd0, "R12 phase in reset", phase_o, 0);
        rst_n = 1;

        // R1 R2 R3 R4 R7: mode table
        foreach (TABLE[k]) begin
            do_reset();
            enter(TABLE[k].idl, TABLE[k].src);
            chk(q4_ok, "R5 entry on phase-3 edge", q4_ok, 1);
            repeat (60) step();
            chk(mode_o == TABLE[k].mode, "R1/R2 mode code", mode_o, TABLE[k].mode);
            chk(pri_osc_en == TABLE[k].pri, "R4 primary osc enable", pri_osc_en, TABLE[k].pri);
            chk({stat_pri, stat_sec, stat_int} == TABLE[k].stat, "R7 status flags",
                {stat_pri, stat_sec, stat_int}, TABLE[k].stat);
            observe(30);
            chk((n_cpu > 0) == TABLE[k].cpu, "R1/R2 cpu clock activity", n_cpu, TABLE[k].cpu);
            chk((n_per > 0) == TABLE[k].per, "R2 peripheral clock activity", n_per, TABLE[k].per);
            if (TABLE[k].mode == 3'd6)
                chk({sec_osc_en, int_osc_en} == 2'b00, "R3 oscillators off in sleep",
                    {sec_osc_en, int_osc_en}, 0);
        end

        // R6: pause of 8 new-source ticks on a switch to secondary
        do_reset();
        enter(1'b0, 2'b01);
        gated = 0; seen = 0;
        for (int i = 0; i < 200; i++) begin
            if (per_clk_en) begin
                seen = sec_tick;
                break;
            end
            if (sec_tick) gated++;
            step();
        end
        chk(gated == 8, "R6 ticks held during switch", gated, 8);
        chk(seen, "R6 first enable on new source tick", seen, 1);

        // R7: slow tap and unstable fast path hide the internal flag
        do_reset();
        tap_slow = 1;
        enter(1'b0, 2'b10);
        repeat (40) step();
        chk({stat_pri, stat_sec, stat_int} == 3'b000, "R7 slow tap shows no flag",
            {stat_pri, stat_sec, stat_int}, 0);
        tap_slow = 0; int_stable = 0; step();
        chk({stat_pri, stat_sec, stat_int} == 3'b000, "R7 unstable shows no flag",
            {stat_pri, stat_sec, stat_int}, 0);
        int_stable = 1; step();
        chk(stat_int == 1'b1, "R7 stable internal flag", stat_int, 1);

        // R8 R11: interrupt wake from secondary idle, primary not yet ready
        do_reset();
        enter(1'b1, 2'b01);
        repeat (60) step();
        pri_ready = 0; gie = 1; irq = 1;
        step();
        irq = 0;
        chk(mode_o == 3'd0, "R8 wake to primary run", mode_o, 0);
        chk(irq_vec_req == 1'b1, "R11 handler request with gie", irq_vec_req, 1);
        step();
        chk(irq_vec_req == 1'b0, "R11 handler request one cycle", irq_vec_req, 0);
        observe(30);
        chk(n_cpu > 0, "R8 cpu runs on old source while waiting", n_cpu, 1);
        chk(stat_sec == 1'b1, "R8 still on secondary", stat_sec, 1);
        pri_ready = 1;
        repeat (50) step();
        chk({stat_pri, stat_sec, stat_int} == 3'b100, "R8 automatic switch to primary",
            {stat_pri, stat_sec, stat_int}, 3'b100);

        // R11: wake without gie
        do_reset();
        enter(1'b1, 2'b10);
        repeat (40) step();
        gie = 0; irq = 1; step(); irq = 0;
        chk(mode_o == 3'd0, "R11 wake without gie", mode_o, 0);
        chk(irq_vec_req == 1'b0, "R11 no handler request without gie", irq_vec_req, 0);

        // R11: interrupt in a run mode is ignored
        do_reset();
        gie = 1; irq = 1; seen = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (irq_vec_req) seen = 1;
        end
        irq = 0;
        chk(seen == 0, "R11 no handler request in run mode", seen, 0);
        chk(mode_o == 3'd0, "R11 run mode kept on interrupt", mode_o, 0);

        // R9: wake from sleep without two-speed start
        do_reset();
        enter(1'b0, 2'b00);
        repeat (10) step();
        pri_ready = 0; twospeed_en = 0; irq = 1; step(); irq = 0;
        observe(30);
        chk(n_cpu == 0, "R9 cpu held until primary ready", n_cpu, 0);
        pri_ready = 1;
        observe(30);
        chk(n_cpu > 0, "R9 cpu runs once primary ready", n_cpu, 1);

        // R9: wake from sleep with two-speed start
        do_reset();
        enter(1'b0, 2'b00);
        repeat (10) step();
        pri_ready = 0; twospeed_en = 1; irq = 1; step(); irq = 0;
        observe(30);
        chk(n_cpu > 0, "R9 cpu runs at once on internal", n_cpu, 1);
        chk(stat_int == 1'b1, "R9 internal flag during two-speed start", stat_int, 1);
        pri_ready = 1;
        repeat (50) step();
        chk(stat_pri == 1'b1, "R9 later switch to primary", stat_pri, 1);

        // R10: time-out in run mode
        do_reset();
        wdt_timeout = 1; step(); wdt_timeout = 0;
        chk(wdt_reset_req == 1'b1, "R10 reset request in run", wdt_reset_req, 1);
        chk(wdt_flag_clr == 1'b1, "R10 clear pulse in run", wdt_flag_clr, 1);
        chk(mode_o == 3'd0, "R10 mode kept in run", mode_o, 0);
        step();
        chk(wdt_reset_req == 1'b0, "R10 reset request one cycle", wdt_reset_req, 0);

        // R10: time-out in idle wakes
        do_reset();
        enter(1'b1, 2'b00);
        repeat (10) step();
        wdt_timeout = 1; step(); wdt_timeout = 0;
        chk(mode_o == 3'd0, "R10 wake from idle", mode_o, 0);
        chk(wdt_reset_req == 1'b0, "R10 no reset request in idle", wdt_reset_req, 0);
        chk(wdt_flag_clr == 1'b1, "R10 clear pulse in idle", wdt_flag_clr, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule